// File: doc/BRIEF.md
# Dual Byte-Wide Parallel Port Controller

This peripheral gives a processor two independent 8-bit parallel ports, A and B, through a small synchronous register bus. The bus has a chip select, a byte offset, read and write strobes, and data in both directions. Each port has three registers: a data register, a direction register that sets each pin as input or output, and a control register. A general control register at the base holds a two-bit port mode field. Only the independent 8-bit mode is acted on. The other encodings, including the joined 16-bit mode, are stored and read back.

Each port has its own strobe line, which the external device pulses. The port's control register picks one of three buffering submodes. The first latches input bytes into a two-entry queue. The second double-buffers output bytes, moving each one to the pins when the device acknowledges. The third passes data straight through in both directions. A per-port status bit shows that data is waiting or that the output buffer is free. When enabled, that bit drives a shared active-high interrupt line. Pins and strobes are brought into the clock domain through two-flop synchronizers.

Top module: `pport_ctl`

## Requirements
- R1: After reset every register reads 0x00, both output-enable buses and both pin latches are 0x00, and `irq` is low.
- R2: Registers sit at these byte offsets, and each reads back the full byte last written:
  - general control 0x00, with the mode in bits 7:6 (the encoding 01 included);
  - spare storage 0x02;
  - direction A 0x04 and direction B 0x06;
  - control A 0x0C and control B 0x0E;
  - data A 0x10 and data B 0x12;
  - status 0x1A, which is read-only.
- R3: A read from any other offset returns 0x00. A write to any other offset leaves every register unchanged.
- R4: Each bit of a port's direction register drives the matching output-enable bit (1 = output, 0 = input). In a data-register read, the output bits always return that port's pin latch.
- R5: The submode is held in control bits 7:6.
  - In submode 00, each rising edge of the port strobe captures the synchronized pins into a two-entry queue.
  - A capture arriving while the queue is full is discarded.
  - The status bit is 1 while the queue holds data.
- R6: In submode 00, a data-register read returns the oldest queued byte on the input bits and removes it from the queue. Reading an empty queue returns 0 on the input bits. Writes go straight to the pin latch.
- R7: In submode 01, a data write fills a holding byte, replacing any earlier unsent byte, and the status bit drops to 0. The next strobe rising edge moves the holding byte to the pin latch and sets the status bit back to 1. Input bits read the live synchronized pins.
- R8: In submodes 10 and 11, writes go straight to the pin latch, input bits read the live pins, the strobe has no effect, and the status bit is 0.
- R9: Status bit 0 belongs to port A and bit 1 to port B; bits 7:2 are 0. `irq` is the OR over both ports of the status bit ANDed with control bit 1.
- R10: Writing a port's control register empties its input queue and marks its holding byte as free.
- R11: Read data appears on `rdata` at the clock edge that samples the read strobe, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| addr | input | 5 | Byte offset |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin latch |
| pa_oe | output | 8 | Port A output enables |
| pa_stb | input | 1 | Port A strobe/acknowledge |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin latch |
| pb_oe | output | 8 | Port B output enables |
| pb_stb | input | 1 | Port B strobe/acknowledge |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest cases to reach are the full input queue dropping a third capture, and a data read on a port with mixed directions. In that read, output bits come from the latch and input bits come from the queue head. The stimulus reaches the first case by enabling the interrupt, then pulsing the strobe three times with distinct pin values before any read. It then drains the queue past empty. For the second case it sets a split direction mask and writes a latch value before a further capture. The reference model in the bench keeps its own queue and holding byte per port. It compares pins, enables and `irq` on every settled clock, and compares `rdata` on each read.

// File: rtl/pport_ctl.sv
module pport_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic [4:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic       pa_stb,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic       pb_stb,
  output logic       irq
);
  localparam logic [4:0] OFF_GC  = 5'h00;
  localparam logic [4:0] OFF_SP  = 5'h02;
  localparam logic [4:0] OFF_DDA = 5'h04;
  localparam logic [4:0] OFF_DDB = 5'h06;
  localparam logic [4:0] OFF_CRA = 5'h0C;
  localparam logic [4:0] OFF_CRB = 5'h0E;
  localparam logic [4:0] OFF_DRA = 5'h10;
  localparam logic [4:0] OFF_DRB = 5'h12;
  localparam logic [4:0] OFF_ST  = 5'h1A;

  logic [7:0]  gcr, spr;
  logic [15:0] pins_all, ddr_all, cr_all, olat_all, dr_all;
  logic [1:0]  stb_all, st;

  wire wr_en = cs & wr;
  wire rd_en = cs & rd;

  assign pins_all = {pb_in, pa_in};
  assign stb_all  = {pb_stb, pa_stb};

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam logic [4:0] A_DD = (p == 0) ? OFF_DDA : OFF_DDB;
    localparam logic [4:0] A_CR = (p == 0) ? OFF_CRA : OFF_CRB;
    localparam logic [4:0] A_DR = (p == 0) ? OFF_DRA : OFF_DRB;

    logic [7:0] ddr, cr, olat, hold, q0, q1, s1, s2;
    logic [1:0] cnt;
    logic       hfull;
    logic [2:0] ssync;

    wire [1:0] sm   = cr[7:6];
    wire       w_dd = wr_en && addr == A_DD;
    wire       w_cr = wr_en && addr == A_CR;
    wire       w_dr = wr_en && addr == A_DR;
    wire       r_dr = rd_en && addr == A_DR;
    wire       rise = ssync[1] & ~ssync[2];
    wire       push = rise && sm == 2'b00 && cnt != 2'd2;
    wire       pop  = r_dr && sm == 2'b00 && cnt != 2'd0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ddr <= '0; cr <= '0; olat <= '0; hold <= '0;
        q0 <= '0; q1 <= '0; s1 <= '0; s2 <= '0;
        cnt <= '0; hfull <= 1'b0; ssync <= '0;
      end else begin
        s1    <= pins_all[p*8 +: 8];
        s2    <= s1;
        ssync <= {ssync[1:0], stb_all[p]};
        if (w_dd) ddr <= wdata;
        if (w_dr && sm != 2'b01) olat <= wdata;
        if (w_cr) begin
          cr    <= wdata;
          cnt   <= '0;
          hfull <= 1'b0;
        end else if (sm == 2'b00) begin
          if (push && pop) begin
            q0 <= s2;
          end else if (push) begin
            if (cnt == 2'd0) q0 <= s2;
            else             q1 <= s2;
            cnt <= cnt + 2'd1;
          end else if (pop) begin
            q0  <= q1;
            cnt <= cnt - 2'd1;
          end
        end else if (sm == 2'b01) begin
          if (rise && hfull) begin
            olat  <= hold;
            hfull <= 1'b0;
          end
          if (w_dr) begin
            hold  <= wdata;
            hfull <= 1'b1;
          end
        end
      end
    end

    wire [7:0] inb = (sm == 2'b00) ? ((cnt != 2'd0) ? q0 : 8'h00) : s2;

    assign st[p]               = (sm == 2'b00) ? (cnt != 2'd0) :
                                 (sm == 2'b01) ? ~hfull : 1'b0;
    assign dr_all[p*8 +: 8]    = (ddr & olat) | (~ddr & inb);
    assign ddr_all[p*8 +: 8]   = ddr;
    assign cr_all[p*8 +: 8]    = cr;
    assign olat_all[p*8 +: 8]  = olat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcr   <= '0;
      spr   <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && addr == OFF_GC) gcr <= wdata;
      if (wr_en && addr == OFF_SP) spr <= wdata;
      if (rd_en) begin
        case (addr)
          OFF_GC:  rdata <= gcr;
          OFF_SP:  rdata <= spr;
          OFF_DDA: rdata <= ddr_all[7:0];
          OFF_DDB: rdata <= ddr_all[15:8];
          OFF_CRA: rdata <= cr_all[7:0];
          OFF_CRB: rdata <= cr_all[15:8];
          OFF_DRA: rdata <= dr_all[7:0];
          OFF_DRB: rdata <= dr_all[15:8];
          OFF_ST:  rdata <= {6'b0, st};
          default: rdata <= 8'h00;
        endcase
      end
    end
  end

  assign pa_out = olat_all[7:0];
  assign pb_out = olat_all[15:8];
  assign pa_oe  = ddr_all[7:0];
  assign pb_oe  = ddr_all[15:8];
  assign irq    = |(st & {cr_all[9], cr_all[1]});
endmodule

// File: rtl/pport_ctl_chk.sv
module pport_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic [4:0] addr,
  input logic       wr,
  input logic       rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic       irq,
  input logic [1:0] st,
  input logic [7:0] cr_a
);
  wire mapped = addr inside {5'h00, 5'h02, 5'h04, 5'h06, 5'h0C, 5'h0E, 5'h10, 5'h12, 5'h1A};
  wire wr_dra = cs && wr && addr == 5'h10;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && !irq)); // R1
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 5'h04) |=> (pa_oe == $past(wdata))); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !mapped) |=> (rdata == 8'h00)); // R3
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dra && cr_a[7:6] != 2'b01) |=> $stable(pa_out)); // R6
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dra && cr_a[7:6] == 2'b01) |=> !st[0]); // R7
endmodule

bind pport_ctl pport_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
  .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_oe(pb_oe), .irq(irq), .st(st), .cr_a(cr_all[7:0])
);

// File: tb/sim_pport_ctl.sv
module sim_pport_ctl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe;
  logic       pa_stb = 1'b0, pb_stb = 1'b0, irq;
  logic [7:0] m_pin [2] = '{8'h00, 8'h00};

  pport_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata),
    .pa_in(m_pin[0]), .pa_out(pa_out), .pa_oe(pa_oe), .pa_stb(pa_stb),
    .pb_in(m_pin[1]), .pb_out(pb_out), .pb_oe(pb_oe), .pb_stb(pb_stb),
    .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  bit settle = 1'b1;
  logic [7:0] m_gcr = 0, m_spr = 0;
  logic [7:0] m_ddr [2] = '{0, 0}, m_cr [2] = '{0, 0}, m_olat [2] = '{0, 0}, m_hold [2] = '{0, 0};
  bit m_hf [2] = '{0, 0};
  logic [7:0] qa[$], qb[$];

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int qsz(int p);
    return (p == 0) ? qa.size() : qb.size();
  endfunction

  function automatic bit m_st(int p);
    case (m_cr[p][7:6])
      2'b00:   return qsz(p) > 0;
      2'b01:   return !m_hf[p];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_irq();
    return (m_st(0) & m_cr[0][1]) | (m_st(1) & m_cr[1][1]);
  endfunction

  function automatic void m_write(logic [4:0] a, logic [7:0] d);
    int p;
    case (a)
      5'h00: m_gcr = d;
      5'h02: m_spr = d;
      5'h04: m_ddr[0] = d;
      5'h06: m_ddr[1] = d;
      5'h0C, 5'h0E: begin
        p = (a == 5'h0C) ? 0 : 1;
        m_cr[p] = d; m_hf[p] = 0;
        if (p == 0) qa.delete(); else qb.delete();
      end
      5'h10, 5'h12: begin
        p = (a == 5'h10) ? 0 : 1;
        if (m_cr[p][7:6] == 2'b01) begin m_hold[p] = d; m_hf[p] = 1; end
        else m_olat[p] = d;
      end
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] m_read(logic [4:0] a);
    int p;
    logic [7:0] inb;
    case (a)
      5'h00: return m_gcr;
      5'h02: return m_spr;
      5'h04: return m_ddr[0];
      5'h06: return m_ddr[1];
      5'h0C: return m_cr[0];
      5'h0E: return m_cr[1];
      5'h1A: return {6'b0, m_st(1), m_st(0)};
      5'h10, 5'h12: begin
        p = (a == 5'h10) ? 0 : 1;
        if (m_cr[p][7:6] == 2'b00) begin
          inb = 8'h00;
          if (p == 0 && qa.size() > 0) inb = qa.pop_front();
          if (p == 1 && qb.size() > 0) inb = qb.pop_front();
        end else inb = m_pin[p];
        return (m_ddr[p] & m_olat[p]) | (~m_ddr[p] & inb);
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic bw(logic [4:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 m_write(a, d);
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic br(logic [4:0] a, string req);
    logic [7:0] e;
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(posedge clk); #1 e = m_read(a);
    @(negedge clk); cs = 0; rd = 0;
    chk(rdata == e, req, rdata, e);
  endtask

  task automatic pulse(int p, logic [7:0] v);
    settle = 1;
    m_pin[p] = v;
    repeat (3) @(negedge clk);
    if (p == 0) pa_stb = 1; else pb_stb = 1;
    repeat (5) @(negedge clk);
    if (p == 0) pa_stb = 0; else pb_stb = 0;
    repeat (5) @(negedge clk);
    case (m_cr[p][7:6])
      2'b00: begin
        if (p == 0 && qa.size() < 2) qa.push_back(v);
        if (p == 1 && qb.size() < 2) qb.push_back(v);
      end
      2'b01: if (m_hf[p]) begin m_olat[p] = m_hold[p]; m_hf[p] = 0; end
      default: ;
    endcase
    settle = 0;
  endtask

  task automatic setpin(int p, logic [7:0] v);
    m_pin[p] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!settle) begin
      chk(pa_out == m_olat[0], "R4 pa_out", pa_out, m_olat[0]);
      chk(pb_out == m_olat[1], "R4 pb_out", pb_out, m_olat[1]);
      chk(pa_oe == m_ddr[0], "R4 pa_oe", pa_oe, m_ddr[0]);
      chk(pb_oe == m_ddr[1], "R4 pb_oe", pb_oe, m_ddr[1]);
      chk(irq == m_irq(), "R9 irq", {7'b0, irq}, {7'b0, m_irq()});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R11 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    settle = 0;
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {7'b0, irq}, 8'h00);
    foreach (m_pin[i]) ;
    br(5'h00, "R1 gcr"); br(5'h02, "R1 spare"); br(5'h04, "R1 ddra");
    br(5'h06, "R1 ddrb"); br(5'h0C, "R1 cra"); br(5'h0E, "R1 crb");
    br(5'h10, "R1 dra"); br(5'h12, "R1 drb"); br(5'h1A, "R1 status");
    // R2 register map and readback
    bw(5'h00, 8'h40); br(5'h00, "R2 gcr mode01");
    bw(5'h02, 8'h5A); br(5'h02, "R2 spare");
    bw(5'h06, 8'hC3); br(5'h06, "R2 ddrb");
    bw(5'h0E, 8'h81); br(5'h0E, "R2 crb");
    // R3 unmapped
    bw(5'h08, 8'hFF); bw(5'h14, 8'hFF); bw(5'h1C, 8'hFF);
    br(5'h08, "R3 unmapped 08"); br(5'h14, "R3 unmapped 14"); br(5'h1C, "R3 unmapped 1C");
    br(5'h04, "R3 ddra kept"); br(5'h06, "R3 ddrb kept"); br(5'h00, "R3 gcr kept");
    // R5 / R6 latched input queue on port A
    bw(5'h0C, 8'h02); bw(5'h04, 8'h00);
    pulse(0, 8'h5A); br(5'h1A, "R5 status after capture");
    pulse(0, 8'h3C); pulse(0, 8'h77);
    br(5'h10, "R6 pop oldest");
    br(5'h1A, "R5 status one left");
    br(5'h10, "R6 pop second, third dropped");
    br(5'h10, "R6 empty read");
    br(5'h1A, "R5 status empty");
    // R4 mixed direction with queue head
    bw(5'h04, 8'hF0); bw(5'h10, 8'hA5);
    pulse(0, 8'h3C);
    br(5'h10, "R4 mixed read");
    // R11 read data holds
    repeat (3) @(negedge clk);
    chk(rdata == 8'hAC, "R11 rdata held", rdata, 8'hAC);
    // R7 double-buffered output on port B
    bw(5'h06, 8'hFF); bw(5'h0E, 8'h42);
    br(5'h1A, "R7 holding free");
    bw(5'h12, 8'h11);
    br(5'h1A, "R7 holding busy");
    pulse(1, 8'h00);
    br(5'h1A, "R7 free after ack");
    br(5'h12, "R7 latch readback");
    bw(5'h12, 8'h22); bw(5'h12, 8'h33);
    pulse(1, 8'h00);
    chk(pb_out == 8'h33, "R7 last write sent", pb_out, 8'h33);
    bw(5'h06, 8'h0F); setpin(1, 8'hC3);
    br(5'h12, "R7 live input bits");
    // R8 transparent on port A
    bw(5'h0C, 8'h80); bw(5'h10, 8'h5F);
    setpin(0, 8'h96);
    br(5'h10, "R8 live read");
    pulse(0, 8'h69);
    br(5'h1A, "R8 strobe ignored status");
    br(5'h10, "R8 live read after strobe");
    // R10 control write flushes
    bw(5'h0C, 8'h02);
    pulse(0, 8'h12); pulse(0, 8'h34);
    br(5'h1A, "R10 status before flush");
    bw(5'h0C, 8'h02);
    br(5'h1A, "R10 status after flush");
    br(5'h10, "R10 queue empty after flush");
    bw(5'h0E, 8'h42);
    br(5'h1A, "R10 holding free after flush");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule